// File: doc/BRIEF.md
# Framed Position Word Serializer with CRC-6

This block turns a captured position value and a set of sensor status flags into one serial frame, which the controller clocks out bit by bit. A frame holds a fixed marker pattern, the position word of a length set at run time, nine status bits, a six-bit check code and a closing marker pattern. The controller drives the serial clock and a request. On the clock edge that samples the request in the idle state, the block latches the position, the length and the flags. It then presents one frame bit per clock period, and each bit changes on the rising edge.

The incoming serial clock is also returned on a dedicated output. The controller can then sample the returned clock and the data at the same physical point, so the cable and driver delays cancel out. Producing the position value is outside this block.

Top module: `posword_framer`

## Requirements
- R1: While reset is asserted, and afterwards until the first request, `sdata` is 0.
- R2: The clock edge that samples `req` high in the idle state starts a frame. In the clock period after that edge `sdata` carries the first frame bit, and the frame opens with the bits 1, 0, 1, 1.
- R3: Next come L position bits, most significant first: `pos[L-1]` down to `pos[0]`. L is `pos_len`, with values below 4 treated as 4 and values above 35 treated as 35. Bits of `pos` at index L and above are not sent.
- R4: Nine status bits follow in this order: `flags[0]` (index window), `flags[1]` (right limit), `flags[2]` (left limit), `flags[3]` (yellow alarm), `flags[4]` (red alarm), `flags[5]` (saturation), `flags[6]` (internal communication error), `flags[7]` (over-speed), and then one reserved bit that is always 0.
- R5: Six check bits follow, sent most significant first. They hold the remainder of the polynomial x^6+x+1, computed serially over the position bits and then the status bits, in wire order, with the register cleared at frame start. Feeding the payload plus the check bits through the same register leaves 0.
- R6: The frame closes with the bits 1, 0, 1, 1, so the frame is L+23 bits long (27 to 58).
- R7: After the last closing bit `sdata` is 0 until the next frame begins. With `req` held high, exactly one 0 bit separates consecutive frames.
- R8: Changes to `req`, `pos`, `pos_len` and `flags` while a frame is in progress do not alter that frame.
- R9: `clk_fb` follows `ser_clk` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Serial clock driven by the controller |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Frame request, sampled on the rising edge while idle |
| pos_len | input | LEN_W (6) | Number of position bits to send |
| pos | input | MAX_POS_W (35) | Position value, right-aligned |
| flags | input | 8 | Status flags, bit 0 sent first |
| sdata | output | 1 | Serial frame data |
| clk_fb | output | 1 | Serial clock returned to the controller |

## Verification
On every cycle the assertions check a set of rules. A request in the idle state must yield a leading 1 and a cleared check register. The latched length must stay within its bounds and must not change mid-frame. The reserved status bit must be 0, and the line must drop to 0 right after the last closing bit. The bench alone can show that whole frames carry the right bits: the position is cut to the clamped length and sent in the right order, the flags appear in their wire order, and the check code matches an independent computation. Only the bench can also show that inputs disturbed mid-frame leave the frame intact, that frames requested back to back have exactly one idle bit between them, and that the returned clock tracks the input.

// File: rtl/posword_pkg.sv
package posword_pkg;
   typedef enum logic [2:0] {
      PH_IDLE, PH_START, PH_POS, PH_STAT, PH_CRC, PH_STOP
   } phase_t;

   localparam logic [3:0] MARK      = 4'b1011;
   localparam int         MARK_W    = 4;
   localparam int         STAT_W    = 9;
   localparam int         FLAG_W    = 8;
   localparam int         CRC_W     = 6;
   localparam logic [5:0] CRC_TAPS  = 6'b000011;
endpackage

// File: rtl/posword_seq.sv
module posword_seq
   import posword_pkg::*;
#(
   parameter int MIN_POS_W = 4,
   parameter int MAX_POS_W = 35,
   parameter int LEN_W     = 6,
   parameter int CW        = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [LEN_W-1:0] len,
   output phase_t           phase,
   output logic [CW-1:0]    cnt,
   output logic [LEN_W-1:0] len_eff,
   output logic [LEN_W-1:0] len_q,
   output logic             start
);
   always_comb begin
      if (len < LEN_W'(MIN_POS_W))      len_eff = LEN_W'(MIN_POS_W);
      else if (len > LEN_W'(MAX_POS_W)) len_eff = LEN_W'(MAX_POS_W);
      else                              len_eff = len;
   end

   assign start = (phase == PH_IDLE) && req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         len_q <= LEN_W'(MIN_POS_W);
      end else begin
         case (phase)
            PH_IDLE: if (req) begin
               phase <= PH_START;
               cnt   <= CW'(MARK_W - 1);
               len_q <= len_eff;
            end
            PH_START: if (cnt == '0) begin
               phase <= PH_POS;
               cnt   <= CW'(len_q - 1'b1);
            end else cnt <= cnt - 1'b1;
            PH_POS: if (cnt == '0) begin
               phase <= PH_STAT;
               cnt   <= CW'(STAT_W - 1);
            end else cnt <= cnt - 1'b1;
            PH_STAT: if (cnt == '0) begin
               phase <= PH_CRC;
               cnt   <= CW'(CRC_W - 1);
            end else cnt <= cnt - 1'b1;
            PH_CRC: if (cnt == '0) begin
               phase <= PH_STOP;
               cnt   <= CW'(MARK_W - 1);
            end else cnt <= cnt - 1'b1;
            PH_STOP: if (cnt == '0) phase <= PH_IDLE;
                     else cnt <= cnt - 1'b1;
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/posword_shift.sv
module posword_shift
   import posword_pkg::*;
#(
   parameter int MAX_POS_W = 35,
   parameter int LEN_W     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [LEN_W-1:0]     len,
   input  logic [MAX_POS_W-1:0] pos,
   input  logic [FLAG_W-1:0]    flags,
   input  logic                 pos_adv,
   input  logic                 stat_adv,
   output logic                 pos_bit,
   output logic                 stat_bit
);
   logic [MAX_POS_W-1:0] pos_sh;
   logic [STAT_W-1:0]    stat_sh;
   logic [STAT_W-1:0]    stat_word;

   // wire order: flags[0] first, reserved zero last
   for (genvar i = 0; i < FLAG_W; i++) begin : g_order
      assign stat_word[STAT_W-1-i] = flags[i];
   end
   assign stat_word[0] = 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_sh  <= '0;
         stat_sh <= '0;
      end else if (load) begin
         pos_sh  <= pos << (MAX_POS_W - int'(len));
         stat_sh <= stat_word;
      end else begin
         if (pos_adv)  pos_sh  <= pos_sh << 1;
         if (stat_adv) stat_sh <= stat_sh << 1;
      end
   end

   assign pos_bit  = pos_sh[MAX_POS_W-1];
   assign stat_bit = stat_sh[STAT_W-1];
endmodule

// File: rtl/posword_crc6.sv
module posword_crc6
   import posword_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             upd,
   input  logic             drain,
   input  logic             din,
   output logic [CRC_W-1:0] crc
);
   logic             fb;
   logic [CRC_W-1:0] nxt;

   assign fb  = crc[CRC_W-1] ^ din;
   assign nxt = {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= '0;
      else if (clr)   crc <= '0;
      else if (upd)   crc <= nxt;
      else if (drain) crc <= {crc[CRC_W-2:0], 1'b0};
   end
endmodule

// File: rtl/posword_framer.sv
module posword_framer
   import posword_pkg::*;
#(
   parameter int MIN_POS_W = 4,
   parameter int MAX_POS_W = 35,
   parameter int LEN_W     = 6
) (
   input  logic                 ser_clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic [LEN_W-1:0]     pos_len,
   input  logic [MAX_POS_W-1:0] pos,
   input  logic [7:0]           flags,
   output logic                 sdata,
   output logic                 clk_fb
);
   localparam int SPAN = (MAX_POS_W > STAT_W) ? MAX_POS_W : STAT_W;
   localparam int CW   = $clog2(SPAN);

   if (MIN_POS_W < 1 || MAX_POS_W < MIN_POS_W) begin : g_bad_range
      $error("position length range is empty");
   end
   if ((1 << LEN_W) <= MAX_POS_W) begin : g_bad_len_w
      $error("LEN_W too narrow for MAX_POS_W");
   end

   phase_t           phase;
   logic [CW-1:0]    cnt;
   logic [LEN_W-1:0] len_eff;
   logic [LEN_W-1:0] len_q;
   logic             start;
   logic             pos_bit;
   logic             stat_bit;
   logic [CRC_W-1:0] crc;
   logic             in_pos;
   logic             in_stat;

   assign in_pos  = (phase == PH_POS);
   assign in_stat = (phase == PH_STAT);

   posword_seq #(
      .MIN_POS_W(MIN_POS_W), .MAX_POS_W(MAX_POS_W), .LEN_W(LEN_W), .CW(CW)
   ) u_seq (
      .clk(ser_clk), .rst_n(rst_n), .req(req), .len(pos_len),
      .phase(phase), .cnt(cnt), .len_eff(len_eff), .len_q(len_q),
      .start(start)
   );

   posword_shift #(.MAX_POS_W(MAX_POS_W), .LEN_W(LEN_W)) u_shift (
      .clk(ser_clk), .rst_n(rst_n), .load(start), .len(len_eff),
      .pos(pos), .flags(flags), .pos_adv(in_pos), .stat_adv(in_stat),
      .pos_bit(pos_bit), .stat_bit(stat_bit)
   );

   posword_crc6 u_crc (
      .clk(ser_clk), .rst_n(rst_n), .clr(start),
      .upd(in_pos | in_stat), .drain(phase == PH_CRC),
      .din(in_pos ? pos_bit : stat_bit), .crc(crc)
   );

   always_comb begin
      case (phase)
         PH_START: sdata = MARK[cnt[1:0]];
         PH_POS:   sdata = pos_bit;
         PH_STAT:  sdata = stat_bit;
         PH_CRC:   sdata = crc[CRC_W-1];
         PH_STOP:  sdata = MARK[cnt[1:0]];
         default:  sdata = 1'b0;
      endcase
   end

   assign clk_fb = ser_clk;
endmodule

// File: rtl/posword_framer_chk.sv
module posword_framer_chk
   import posword_pkg::*;
#(
   parameter int MIN_POS_W = 4,
   parameter int MAX_POS_W = 35,
   parameter int LEN_W     = 6,
   parameter int CW        = 6
) (
   input logic             ser_clk,
   input logic             rst_n,
   input logic             req,
   input logic             sdata,
   input phase_t           phase,
   input logic [CW-1:0]    cnt,
   input logic [LEN_W-1:0] len_q,
   input logic [CRC_W-1:0] crc
);
   a_r2_lead_one: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (phase == PH_IDLE && req) |=> sdata);

   a_r5_crc_cleared: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (phase == PH_IDLE && req) |=> (crc == '0));

   a_r3_len_bounds: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (len_q >= LEN_W'(MIN_POS_W)) && (len_q <= LEN_W'(MAX_POS_W)));

   a_r8_len_hold: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> $stable(len_q));

   a_r4_reserved_zero: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (phase == PH_STAT && cnt == '0) |-> !sdata);

   a_r7_quiet_after: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (phase == PH_STOP && cnt == '0) |=> (!sdata && phase == PH_IDLE));
endmodule

bind posword_framer posword_framer_chk #(
   .MIN_POS_W(MIN_POS_W), .MAX_POS_W(MAX_POS_W), .LEN_W(LEN_W), .CW(CW)
) u_chk (
   .ser_clk(ser_clk), .rst_n(rst_n), .req(req), .sdata(sdata),
   .phase(phase), .cnt(cnt), .len_q(len_q), .crc(crc)
);

// File: tb/posword_framer_test.sv
`timescale 1ns/1ps
module posword_framer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [5:0]  pos_len = '0;
   logic [34:0] pos = '0;
   logic [7:0]  flags = '0;
   logic        sdata, clk_fb;
   int          compared = 0;
   int          mismatched = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   posword_framer uut (
      .ser_clk(clk), .rst_n(rst_n), .req(req), .pos_len(pos_len),
      .pos(pos), .flags(flags), .sdata(sdata), .clk_fb(clk_fb)
   );

   task automatic chk(input string r, input logic [63:0] got, input logic [63:0] exp);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: got %h expected %h", r, got, exp);
      end
   endtask

   function automatic logic [5:0] crc_run(input logic [63:0] bits, input int n,
                                          input logic [5:0] init);
      logic [5:0] c = init;
      for (int i = n - 1; i >= 0; i--) begin
         logic f = c[5] ^ bits[i];
         c = {c[4:0], 1'b0};
         if (f) c = c ^ 6'b000011;
      end
      return c;
   endfunction

   // sends one frame and checks every field; hold keeps req high for a back-to-back frame
   task automatic send(input int l, input logic [34:0] p, input logic [7:0] f, input bit hold);
      logic [63:0] b = '0;
      int L = (l < 4) ? 4 : (l > 35 ? 35 : l);
      int n = L + 23;
      logic [63:0] gs = '0, gp = '0, gt = '0, gc = '0, ge = '0;
      logic [63:0] ep = '0, et = '0, pay = '0;
      logic [5:0]  ec;
      @(negedge clk);
      req = 1'b1; pos_len = 6'(l); pos = p; flags = f;
      @(negedge clk);
      if (!hold) begin
         req = 1'b0; pos = ~p; flags = ~f; pos_len = 6'(l + 9);  // R8 disturbance
      end
      b[0] = sdata;
      for (int k = 1; k < n; k++) begin
         @(negedge clk);
         if (!hold && k == 6) req = 1'b1;
         if (!hold && k == 7) req = 1'b0;
         b[k] = sdata;
      end
      for (int k = 0; k < 4; k++) gs = {gs[62:0], b[k]};
      for (int k = 0; k < L; k++) gp = {gp[62:0], b[4+k]};
      for (int k = 0; k < 9; k++) gt = {gt[62:0], b[4+L+k]};
      for (int k = 0; k < 6; k++) gc = {gc[62:0], b[13+L+k]};
      for (int k = 0; k < 4; k++) ge = {ge[62:0], b[19+L+k]};
      for (int k = 0; k < L; k++) ep[k] = p[k];
      for (int k = 0; k < 8; k++) et[8-k] = f[k];
      pay = (ep << 9) | et;
      ec = crc_run(pay, L + 9, 6'd0);
      chk("R2 start mark", gs, 64'hB);
      chk("R3 position bits", gp, ep);
      chk("R4 status bits", gt, et);
      chk("R5 check bits", gc, {58'd0, ec});
      chk("R5 residue", {58'd0, crc_run((pay << 6) | gc, L + 15, 6'd0)}, 64'd0);
      chk("R6 stop mark", ge, 64'hB);
      @(negedge clk);
      chk("R7 idle after frame", {63'd0, sdata}, 64'd0);
      if (hold) begin
         @(negedge clk); chk("R7 next frame bit0", {63'd0, sdata}, 64'd1);
         @(negedge clk); chk("R7 next frame bit1", {63'd0, sdata}, 64'd0);
         req = 1'b0;
         repeat (62) @(negedge clk);
         chk("R7 idle after drain", {63'd0, sdata}, 64'd0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 data in reset", {63'd0, sdata}, 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 data after reset", {63'd0, sdata}, 64'd0);
      chk("R9 fb low", {63'd0, clk_fb}, 64'd0);
      @(posedge clk); #1;
      chk("R9 fb high", {63'd0, clk_fb}, 64'd1);

      // length sweep including clamped values below 4 and above 35
      for (int l = 0; l < 41; l++)
         send(l, 35'h5A5A5A5A5 ^ (35'(l) * 35'h1234567), 8'(l * 29), 1'b0);
      send(63, 35'h7FFFFFFFF, 8'hFF, 1'b0);
      // single-flag walk and extremes of the status field
      for (int i = 0; i < 8; i++) send(12, 35'h00000ABC, 8'(1 << i), 1'b0);
      send(20, '0, 8'h00, 1'b0);
      send(35, '1, 8'hFF, 1'b0);
      // back-to-back frames with req held high
      send(9, 35'h000001F3, 8'hA5, 1'b1);

      @(negedge clk);
      chk("R9 fb low end", {63'd0, clk_fb}, 64'd0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule